// File: doc/BRIEF.md
# Video Mode Timing Legalizer

This block takes a requested video mode line and turns it into one that a display timing generator can actually produce. The request has eight values. Horizontally it gives the display end, sync start, sync end and total, in pixels. Vertically it gives the same four values, in lines. A start pulse copies the request into working registers. The block then runs a fixed sequence of seventeen adjustment steps, one per clock. Each step rounds or clamps one or more fields, using the values left by the steps before it.

When the last step is done, the block pulses `done` and presents the corrected values. A `changed` output reports whether any field differs from what was requested. A generation-select input sets the upper limits on display width and height. It is sampled together with the request. Because each step reads what earlier steps left behind, the order of the steps is part of the behaviour.

Top module: `mode_timing_legalizer`

## Requirements
- R1: While reset is held low and after it is released, `busy`, `done`, `changed` and all eight outputs are zero until the first accepted start.
- R2: A start seen while `busy` is low is accepted at that clock edge. From the next cycle, `busy` stays high for exactly 17 cycles. `done` is high for the single cycle in which `busy` has just gone low again.
- R3: A start seen while `busy` is high has no effect. The result comes only from the request and generation-select captured at the accepted start.
- R4: The first step clears bits [2:0] of all four horizontal fields, so every horizontal output is a multiple of 8.
- R5: The second step caps the horizontal fields: display end at 4072, sync start at 4080, sync end at 4088 and total at 4128.
- R6: Horizontal display end is then raised to at least 640. After that it is lowered to at most 2048 when the captured generation-select is 1, or 1920 when it is 0.
- R7: The horizontal total is then raised to at least display end + 80. After that it is lowered to at most display end + 1016.
- R8: Three steps follow, in this order. Sync end is lowered to at most total − 8. Sync start is raised to at least display end + 8. Sync end is lowered to at most sync start + 248.
- R9: The vertical fields are capped: display end at 2045, sync start at 2046, sync end at 2047 and total at 2049.
- R10: Vertical display end is raised to at least 480. After that it is lowered to at most 1536 when the captured generation-select is 1, or 1440 when it is 0.
- R11: The vertical total is raised to at least display end + 3. After that it is lowered to at most display end + 255.
- R12: Three steps follow, in this order. Sync end is lowered to at most total − 1. Sync start is raised to at least display end + 1. Sync end is lowered to at most sync start + 15.
- R13: When `done` is high, `changed` is 1 exactly when at least one of the eight outputs differs from the matching captured request field.
- R14: While no run is in progress, the outputs and `changed` hold their values, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch a legalization run; ignored while busy |
| gen_sel | input | 1 | 1 selects the wide/tall display limits, 0 the narrow/short ones |
| req_h_disp | input | W | Requested horizontal display end, pixels |
| req_h_sync_beg | input | W | Requested horizontal sync start, pixels |
| req_h_sync_end | input | W | Requested horizontal sync end, pixels |
| req_h_total | input | W | Requested horizontal total, pixels |
| req_v_disp | input | W | Requested vertical display end, lines |
| req_v_sync_beg | input | W | Requested vertical sync start, lines |
| req_v_sync_end | input | W | Requested vertical sync end, lines |
| req_v_total | input | W | Requested vertical total, lines |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| changed | output | 1 | Result differs from the captured request |
| out_h_disp | output | W | Legal horizontal display end |
| out_h_sync_beg | output | W | Legal horizontal sync start |
| out_h_sync_end | output | W | Legal horizontal sync end |
| out_h_total | output | W | Legal horizontal total |
| out_v_disp | output | W | Legal vertical display end |
| out_v_sync_beg | output | W | Legal vertical sync start |
| out_v_sync_end | output | W | Legal vertical sync end |
| out_v_total | output | W | Legal vertical total |

## Verification
The window properties on the finished result assume two things about the request. No field is so large that the working sums overflow W bits. Also, the generation-select limits sit above the minimum display sizes, so the lower clamps never fight the upper ones. With the default 16-bit width, every sum stays far below the overflow point, even for an all-ones request. The bench drives only such requests: legal modes, small unaligned values, all-ones values, and cases that pull sync positions across each other. The hold property assumes that a run starts only through `start` while the block is idle. The bench raises `start` at other times only to show that it is ignored.

// File: rtl/mtv_pkg.sv
// Package: shared constants for the mode timing legalizer.
// Assumes: the eight timing fields are kept in one packed vector, indexed as below.
package mtv_pkg;

    // Field slots inside the packed working vector.
    localparam int F_H_DISP  = 0;
    localparam int F_H_SBEG  = 1;
    localparam int F_H_SEND  = 2;
    localparam int F_H_TOT   = 3;
    localparam int F_V_DISP  = 4;
    localparam int F_V_SBEG  = 5;
    localparam int F_V_SEND  = 6;
    localparam int F_V_TOT   = 7;
    localparam int NUM_FIELDS = 8;

    // The ordered adjustment steps; the order is part of the behaviour.
    typedef enum logic [4:0] {
        ST_H_ROUND     = 5'd0,
        ST_H_CAP       = 5'd1,
        ST_H_DISP_LO   = 5'd2,
        ST_H_DISP_HI   = 5'd3,
        ST_H_TOT_LO    = 5'd4,
        ST_H_TOT_HI    = 5'd5,
        ST_H_SEND_TOT  = 5'd6,
        ST_H_SBEG_DISP = 5'd7,
        ST_H_SEND_LEN  = 5'd8,
        ST_V_CAP       = 5'd9,
        ST_V_DISP_LO   = 5'd10,
        ST_V_DISP_HI   = 5'd11,
        ST_V_TOT_LO    = 5'd12,
        ST_V_TOT_HI    = 5'd13,
        ST_V_SEND_TOT  = 5'd14,
        ST_V_SBEG_DISP = 5'd15,
        ST_V_SEND_LEN  = 5'd16
    } step_e;

    localparam int NUM_STEPS = 17;
    localparam int STEP_W    = 5;

endpackage

// File: rtl/mtv_sequencer.sv
// Module: mtv_sequencer
// Walks the step index from the first to the last step, one step per clock.
// Assumes: start is only acted on while idle; done is a one-cycle pulse that
// coincides with busy falling.
module mtv_sequencer
    import mtv_pkg::*;
#(
    parameter int STEPS = NUM_STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              load,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] step_idx
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    logic              busy_q;
    logic              done_q;
    logic [STEP_W-1:0] step_q;

    // Accept a new run only while idle.
    always_comb load = start && !busy_q;

    // Step counter and run-state flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (busy_q) begin
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign step_idx = step_q;
endmodule

// File: rtl/mtv_clamp_path.sv
// Module: mtv_clamp_path
// Holds the eight working fields and applies one rounding or clamp step per
// enabled cycle, selected by the step index.
// Assumes: limits are chosen so no sum below overflows W bits; the minimum
// display sizes lie below both generation maxima.
module mtv_clamp_path
    import mtv_pkg::*;
#(
    parameter int W            = 16,
    parameter int H_ALIGN_BITS = 3,
    parameter int H_FIELD_BITS = 9,
    parameter int V_FIELD_BITS = 11,
    parameter int H_DISP_MIN   = 640,
    parameter int H_DISP_WIDE  = 2048,
    parameter int H_DISP_NARROW = 1920,
    parameter int V_DISP_MIN   = 480,
    parameter int V_DISP_TALL  = 1536,
    parameter int V_DISP_SHORT = 1440,
    parameter int H_BLANK_MIN  = 80,
    parameter int H_BLANK_MAX  = 1016,
    parameter int H_SYNC_MAX   = 248,
    parameter int V_BLANK_MIN  = 3,
    parameter int V_BLANK_MAX  = 255,
    parameter int V_SYNC_MAX   = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          gen_sel,
    input  logic [NUM_FIELDS-1:0][W-1:0]  req_vals,
    input  logic                          step_en,
    input  logic [STEP_W-1:0]             step_idx,
    output logic [NUM_FIELDS-1:0][W-1:0]  cur_vals
);
    // Derived limits.
    localparam int H_TOP     = (1 << H_FIELD_BITS) - 1;
    localparam int V_TOP     = (1 << V_FIELD_BITS) - 1;
    localparam int H_GRAN    = 1 << H_ALIGN_BITS;
    localparam logic [W-1:0] HC_DISP = W'((H_TOP - 2) << H_ALIGN_BITS);
    localparam logic [W-1:0] HC_SBEG = W'((H_TOP - 1) << H_ALIGN_BITS);
    localparam logic [W-1:0] HC_SEND = W'(H_TOP << H_ALIGN_BITS);
    localparam logic [W-1:0] HC_TOT  = W'((H_TOP + 5) << H_ALIGN_BITS);
    localparam logic [W-1:0] VC_DISP = W'(V_TOP - 2);
    localparam logic [W-1:0] VC_SBEG = W'(V_TOP - 1);
    localparam logic [W-1:0] VC_SEND = W'(V_TOP);
    localparam logic [W-1:0] VC_TOT  = W'(V_TOP + 2);
    localparam logic [W-1:0] ALIGN_MASK = ~W'(H_GRAN - 1);

    logic [NUM_FIELDS-1:0][W-1:0] work_q;
    logic [NUM_FIELDS-1:0][W-1:0] work_d;
    logic                         wide_q;

    function automatic logic [W-1:0] at_most(input logic [W-1:0] v, input logic [W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [W-1:0] at_least(input logic [W-1:0] v, input logic [W-1:0] lim);
        return (v < lim) ? lim : v;
    endfunction

    // Next value of the working fields for the current step.
    always_comb begin
        work_d = work_q;
        case (step_e'(step_idx))
            ST_H_ROUND: begin
                work_d[F_H_DISP] = work_q[F_H_DISP] & ALIGN_MASK;
                work_d[F_H_SBEG] = work_q[F_H_SBEG] & ALIGN_MASK;
                work_d[F_H_SEND] = work_q[F_H_SEND] & ALIGN_MASK;
                work_d[F_H_TOT]  = work_q[F_H_TOT]  & ALIGN_MASK;
            end
            ST_H_CAP: begin
                work_d[F_H_DISP] = at_most(work_q[F_H_DISP], HC_DISP);
                work_d[F_H_SBEG] = at_most(work_q[F_H_SBEG], HC_SBEG);
                work_d[F_H_SEND] = at_most(work_q[F_H_SEND], HC_SEND);
                work_d[F_H_TOT]  = at_most(work_q[F_H_TOT],  HC_TOT);
            end
            ST_H_DISP_LO:
                work_d[F_H_DISP] = at_least(work_q[F_H_DISP], W'(H_DISP_MIN));
            ST_H_DISP_HI:
                work_d[F_H_DISP] = at_most(work_q[F_H_DISP],
                                           wide_q ? W'(H_DISP_WIDE) : W'(H_DISP_NARROW));
            ST_H_TOT_LO:
                work_d[F_H_TOT] = at_least(work_q[F_H_TOT], work_q[F_H_DISP] + W'(H_BLANK_MIN));
            ST_H_TOT_HI:
                work_d[F_H_TOT] = at_most(work_q[F_H_TOT], work_q[F_H_DISP] + W'(H_BLANK_MAX));
            ST_H_SEND_TOT:
                work_d[F_H_SEND] = at_most(work_q[F_H_SEND], work_q[F_H_TOT] - W'(H_GRAN));
            ST_H_SBEG_DISP:
                work_d[F_H_SBEG] = at_least(work_q[F_H_SBEG], work_q[F_H_DISP] + W'(H_GRAN));
            ST_H_SEND_LEN:
                work_d[F_H_SEND] = at_most(work_q[F_H_SEND], work_q[F_H_SBEG] + W'(H_SYNC_MAX));
            ST_V_CAP: begin
                work_d[F_V_DISP] = at_most(work_q[F_V_DISP], VC_DISP);
                work_d[F_V_SBEG] = at_most(work_q[F_V_SBEG], VC_SBEG);
                work_d[F_V_SEND] = at_most(work_q[F_V_SEND], VC_SEND);
                work_d[F_V_TOT]  = at_most(work_q[F_V_TOT],  VC_TOT);
            end
            ST_V_DISP_LO:
                work_d[F_V_DISP] = at_least(work_q[F_V_DISP], W'(V_DISP_MIN));
            ST_V_DISP_HI:
                work_d[F_V_DISP] = at_most(work_q[F_V_DISP],
                                           wide_q ? W'(V_DISP_TALL) : W'(V_DISP_SHORT));
            ST_V_TOT_LO:
                work_d[F_V_TOT] = at_least(work_q[F_V_TOT], work_q[F_V_DISP] + W'(V_BLANK_MIN));
            ST_V_TOT_HI:
                work_d[F_V_TOT] = at_most(work_q[F_V_TOT], work_q[F_V_DISP] + W'(V_BLANK_MAX));
            ST_V_SEND_TOT:
                work_d[F_V_SEND] = at_most(work_q[F_V_SEND], work_q[F_V_TOT] - W'(1));
            ST_V_SBEG_DISP:
                work_d[F_V_SBEG] = at_least(work_q[F_V_SBEG], work_q[F_V_DISP] + W'(1));
            ST_V_SEND_LEN:
                work_d[F_V_SEND] = at_most(work_q[F_V_SEND], work_q[F_V_SBEG] + W'(V_SYNC_MAX));
            default: work_d = work_q;
        endcase
    end

    // Working registers: capture on load, advance on each enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            work_q <= req_vals;
            wide_q <= gen_sel;
        end else if (step_en) begin
            work_q <= work_d;
        end
    end

    assign cur_vals = work_q;
endmodule

// File: rtl/mtv_change_detect.sv
// Module: mtv_change_detect
// Keeps a copy of the request captured at load and flags any field of the
// working set that differs from it.
// Assumes: load is the same strobe that loads the working registers.
module mtv_change_detect
    import mtv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [NUM_FIELDS-1:0][W-1:0]  req_vals,
    input  logic [NUM_FIELDS-1:0][W-1:0]  cur_vals,
    output logic                          changed
);
    logic [NUM_FIELDS-1:0][W-1:0] orig_q;
    logic [NUM_FIELDS-1:0]        differs;

    // Snapshot of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) orig_q <= '0;
        else if (load) orig_q <= req_vals;
    end

    // One comparator per field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        assign differs[g] = (orig_q[g] != cur_vals[g]);
    end

    // Any field moved.
    always_comb changed = |differs;
endmodule

// File: rtl/mode_timing_legalizer.sv
// Module: mode_timing_legalizer (top)
// Turns a requested mode line into a legal one through an ordered series of
// one-per-clock rounding and clamp steps, then pulses done.
// Assumes: request fields are small enough that working sums fit in W bits.
module mode_timing_legalizer
    import mtv_pkg::*;
#(
    parameter int W             = 16,
    parameter int H_ALIGN_BITS  = 3,
    parameter int H_FIELD_BITS  = 9,
    parameter int V_FIELD_BITS  = 11,
    parameter int H_DISP_MIN    = 640,
    parameter int H_DISP_WIDE   = 2048,
    parameter int H_DISP_NARROW = 1920,
    parameter int V_DISP_MIN    = 480,
    parameter int V_DISP_TALL   = 1536,
    parameter int V_DISP_SHORT  = 1440,
    parameter int H_BLANK_MIN   = 80,
    parameter int H_BLANK_MAX   = 1016,
    parameter int H_SYNC_MAX    = 248,
    parameter int V_BLANK_MIN   = 3,
    parameter int V_BLANK_MAX   = 255,
    parameter int V_SYNC_MAX    = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         gen_sel,
    input  logic [W-1:0] req_h_disp,
    input  logic [W-1:0] req_h_sync_beg,
    input  logic [W-1:0] req_h_sync_end,
    input  logic [W-1:0] req_h_total,
    input  logic [W-1:0] req_v_disp,
    input  logic [W-1:0] req_v_sync_beg,
    input  logic [W-1:0] req_v_sync_end,
    input  logic [W-1:0] req_v_total,
    output logic         busy,
    output logic         done,
    output logic         changed,
    output logic [W-1:0] out_h_disp,
    output logic [W-1:0] out_h_sync_beg,
    output logic [W-1:0] out_h_sync_end,
    output logic [W-1:0] out_h_total,
    output logic [W-1:0] out_v_disp,
    output logic [W-1:0] out_v_sync_beg,
    output logic [W-1:0] out_v_sync_end,
    output logic [W-1:0] out_v_total
);
    logic                         load;
    logic [STEP_W-1:0]            step_idx;
    logic [NUM_FIELDS-1:0][W-1:0] req_vals;
    logic [NUM_FIELDS-1:0][W-1:0] cur_vals;

    // Pack the request ports into field slots.
    always_comb begin
        req_vals[F_H_DISP] = req_h_disp;
        req_vals[F_H_SBEG] = req_h_sync_beg;
        req_vals[F_H_SEND] = req_h_sync_end;
        req_vals[F_H_TOT]  = req_h_total;
        req_vals[F_V_DISP] = req_v_disp;
        req_vals[F_V_SBEG] = req_v_sync_beg;
        req_vals[F_V_SEND] = req_v_sync_end;
        req_vals[F_V_TOT]  = req_v_total;
    end

    mtv_sequencer #(.STEPS(NUM_STEPS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .busy     (busy),
        .done     (done),
        .step_idx (step_idx)
    );

    mtv_clamp_path #(
        .W(W), .H_ALIGN_BITS(H_ALIGN_BITS), .H_FIELD_BITS(H_FIELD_BITS),
        .V_FIELD_BITS(V_FIELD_BITS), .H_DISP_MIN(H_DISP_MIN),
        .H_DISP_WIDE(H_DISP_WIDE), .H_DISP_NARROW(H_DISP_NARROW),
        .V_DISP_MIN(V_DISP_MIN), .V_DISP_TALL(V_DISP_TALL),
        .V_DISP_SHORT(V_DISP_SHORT), .H_BLANK_MIN(H_BLANK_MIN),
        .H_BLANK_MAX(H_BLANK_MAX), .H_SYNC_MAX(H_SYNC_MAX),
        .V_BLANK_MIN(V_BLANK_MIN), .V_BLANK_MAX(V_BLANK_MAX),
        .V_SYNC_MAX(V_SYNC_MAX)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .gen_sel  (gen_sel),
        .req_vals (req_vals),
        .step_en  (busy),
        .step_idx (step_idx),
        .cur_vals (cur_vals)
    );

    mtv_change_detect #(.W(W)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .req_vals (req_vals),
        .cur_vals (cur_vals),
        .changed  (changed)
    );

    // Unpack the working fields onto the result ports.
    always_comb begin
        out_h_disp     = cur_vals[F_H_DISP];
        out_h_sync_beg = cur_vals[F_H_SBEG];
        out_h_sync_end = cur_vals[F_H_SEND];
        out_h_total    = cur_vals[F_H_TOT];
        out_v_disp     = cur_vals[F_V_DISP];
        out_v_sync_beg = cur_vals[F_V_SBEG];
        out_v_sync_end = cur_vals[F_V_SEND];
        out_v_total    = cur_vals[F_V_TOT];
    end
endmodule

// File: rtl/mtv_checker.sv
// Module: mtv_checker
// Port-level properties of the legalizer, attached through bind.
// Assumes: working sums never overflow W bits (see the brief).
module mtv_checker #(
    parameter int W           = 16,
    parameter int STEPS       = 17,
    parameter int H_DISP_MIN  = 640,
    parameter int H_DISP_WIDE = 2048,
    parameter int V_DISP_MIN  = 480,
    parameter int V_DISP_TALL = 1536
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         changed,
    input logic [W-1:0] out_h_disp,
    input logic [W-1:0] out_h_sync_beg,
    input logic [W-1:0] out_h_sync_end,
    input logic [W-1:0] out_h_total,
    input logic [W-1:0] out_v_disp,
    input logic [W-1:0] out_v_sync_beg,
    input logic [W-1:0] out_v_sync_end,
    input logic [W-1:0] out_v_total
);
    logic [7:0] run_cnt;

    // Counts the cycles busy has been high in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else run_cnt <= '0;
    end

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 8'(STEPS)));
    a_r4_h_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_h_disp[2:0] == 3'd0 && out_h_sync_beg[2:0] == 3'd0 &&
                  out_h_sync_end[2:0] == 3'd0 && out_h_total[2:0] == 3'd0));
    a_r6_h_disp_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_h_disp >= W'(H_DISP_MIN) && out_h_disp <= W'(H_DISP_WIDE)));
    a_r7_h_total_window: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_h_total >= out_h_disp + W'(80) && out_h_total <= out_h_disp + W'(1016)));
    a_r8_h_sync_place: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_h_sync_beg >= out_h_disp + W'(8) &&
                  out_h_sync_end <= out_h_total - W'(8) &&
                  out_h_sync_end <= out_h_sync_beg + W'(248)));
    a_r10_v_disp_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_v_disp >= W'(V_DISP_MIN) && out_v_disp <= W'(V_DISP_TALL)));
    a_r11_v_total_window: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_v_total >= out_v_disp + W'(3) && out_v_total <= out_v_disp + W'(255)));
    a_r12_v_sync_place: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_v_sync_beg >= out_v_disp + W'(1) &&
                  out_v_sync_end <= out_v_total - W'(1) &&
                  out_v_sync_end <= out_v_sync_beg + W'(15)));
    a_r14_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |->
            ($stable(out_h_disp) && $stable(out_h_sync_beg) && $stable(out_h_sync_end) &&
             $stable(out_h_total) && $stable(out_v_disp) && $stable(out_v_sync_beg) &&
             $stable(out_v_sync_end) && $stable(out_v_total) && $stable(changed)));
endmodule

bind mode_timing_legalizer mtv_checker #(
    .W(W), .STEPS(17), .H_DISP_MIN(H_DISP_MIN), .H_DISP_WIDE(H_DISP_WIDE),
    .V_DISP_MIN(V_DISP_MIN), .V_DISP_TALL(V_DISP_TALL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .changed(changed), .out_h_disp(out_h_disp), .out_h_sync_beg(out_h_sync_beg),
    .out_h_sync_end(out_h_sync_end), .out_h_total(out_h_total),
    .out_v_disp(out_v_disp), .out_v_sync_beg(out_v_sync_beg),
    .out_v_sync_end(out_v_sync_end), .out_v_total(out_v_total)
);

// File: tb/mode_timing_legalizer_tb.sv
// Directed bench for the mode timing legalizer; one task per scenario.
module mode_timing_legalizer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         gen_sel = 1'b0;
    logic [W-1:0] r_hd = '0, r_hsb = '0, r_hse = '0, r_ht = '0;
    logic [W-1:0] r_vd = '0, r_vsb = '0, r_vse = '0, r_vt = '0;
    logic         busy, done, changed;
    logic [W-1:0] o_hd, o_hsb, o_hse, o_ht, o_vd, o_vsb, o_vse, o_vt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_timing_legalizer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gen_sel(gen_sel),
        .req_h_disp(r_hd), .req_h_sync_beg(r_hsb), .req_h_sync_end(r_hse), .req_h_total(r_ht),
        .req_v_disp(r_vd), .req_v_sync_beg(r_vsb), .req_v_sync_end(r_vse), .req_v_total(r_vt),
        .busy(busy), .done(done), .changed(changed),
        .out_h_disp(o_hd), .out_h_sync_beg(o_hsb), .out_h_sync_end(o_hse), .out_h_total(o_ht),
        .out_v_disp(o_vd), .out_v_sync_beg(o_vsb), .out_v_sync_end(o_vse), .out_v_total(o_vt)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int lo(input int v, input int l); return (v < l) ? l : v; endfunction
    function automatic int hi(input int v, input int l); return (v > l) ? l : v; endfunction

    // Expected result, written from the requirement list in step order.
    function automatic void expect_of(input int r[8], input bit g, output int e[8]);
        for (int i = 0; i < 8; i++) e[i] = r[i];
        for (int i = 0; i < 4; i++) e[i] = e[i] & ~7;              // R4
        e[0] = hi(e[0], 4072); e[1] = hi(e[1], 4080);                // R5
        e[2] = hi(e[2], 4088); e[3] = hi(e[3], 4128);
        e[0] = lo(e[0], 640);  e[0] = hi(e[0], g ? 2048 : 1920);     // R6
        e[3] = lo(e[3], e[0] + 80); e[3] = hi(e[3], e[0] + 1016);    // R7
        e[2] = hi(e[2], e[3] - 8); e[1] = lo(e[1], e[0] + 8);        // R8
        e[2] = hi(e[2], e[1] + 248);
        e[4] = hi(e[4], 2045); e[5] = hi(e[5], 2046);                // R9
        e[6] = hi(e[6], 2047); e[7] = hi(e[7], 2049);
        e[4] = lo(e[4], 480);  e[4] = hi(e[4], g ? 1536 : 1440);     // R10
        e[7] = lo(e[7], e[4] + 3); e[7] = hi(e[7], e[4] + 255);      // R11
        e[6] = hi(e[6], e[7] - 1); e[5] = lo(e[5], e[4] + 1);        // R12
        e[6] = hi(e[6], e[5] + 15);
    endfunction

    task automatic drive_req(input int r[8], input bit g);
        r_hd = W'(r[0]); r_hsb = W'(r[1]); r_hse = W'(r[2]); r_ht = W'(r[3]);
        r_vd = W'(r[4]); r_vsb = W'(r[5]); r_vse = W'(r[6]); r_vt = W'(r[7]);
        gen_sel = g;
    endtask

    // Launch a run and check its cycle timing (R2); optionally pulse start mid-run.
    task automatic launch(input int r[8], input bit g, input bit poke, input int p[8]);
        @(negedge clk);
        drive_req(r, g);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R2", "busy after accepted start", int'(busy), 1);
        for (int c = 1; c < 17; c++) begin
            if (poke && c == 3) begin
                drive_req(p, ~g);  // R3: a start while busy must be ignored
                start = 1'b1;
            end
            @(posedge clk); #1;
            start = 1'b0;
        end
        chk("R2", "busy on last step", int'(busy), 1);
        chk("R2", "done before last step", int'(done), 0);
        @(posedge clk); #1;
        chk("R2", "done pulse", int'(done), 1);
        chk("R2", "busy at done", int'(busy), 0);
    endtask

    task automatic compare_all(input string tag, input int r[8], input bit g);
        int e[8];
        bit any;
        expect_of(r, g, e);
        chk(tag, "h_disp R6", int'(o_hd), e[0]);
        chk(tag, "h_total R7", int'(o_ht), e[3]);
        chk(tag, "h_sync_beg R8", int'(o_hsb), e[1]);
        chk(tag, "h_sync_end R8", int'(o_hse), e[2]);
        chk(tag, "v_disp R10", int'(o_vd), e[4]);
        chk(tag, "v_total R11", int'(o_vt), e[7]);
        chk(tag, "v_sync_beg R12", int'(o_vsb), e[5]);
        chk(tag, "v_sync_end R12", int'(o_vse), e[6]);
        any = 1'b0;
        for (int i = 0; i < 8; i++) if (e[i] != r[i]) any = 1'b1;
        chk(tag, "changed flag R13", int'(changed), int'(any));
    endtask

    task automatic t_reset();
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "out_h_total in reset", int'(o_ht), 0);
        chk("R1", "changed in reset", int'(changed), 0);
    endtask

    task automatic t_legal();
        int r[8] = '{1024, 1048, 1184, 1344, 768, 771, 777, 806};
        int z[8] = '{default: 0};
        launch(r, 1'b1, 1'b0, z);
        compare_all("legal", r, 1'b1);
        chk("R13", "legal mode untouched", int'(changed), 0);
        @(posedge clk); #1;
        chk("R2", "done drops after one cycle", int'(done), 0);
    endtask

    task automatic t_caps();
        int r[8] = '{default: 65535};
        int z[8] = '{default: 0};
        launch(r, 1'b1, 1'b0, z);
        compare_all("caps", r, 1'b1);
        chk("R5", "h sync start capped", int'(o_hsb), 4080);
        chk("R9", "v sync start capped", int'(o_vsb), 2046);
        chk("R4", "h total aligned", int'(o_ht) & 7, 0);
    endtask

    task automatic t_gen_sel();
        int r[8] = '{2100, 2200, 2300, 2600, 1500, 1510, 1515, 1600};
        int z[8] = '{default: 0};
        launch(r, 1'b0, 1'b0, z);
        compare_all("narrow", r, 1'b0);
        chk("R6", "narrow width max", int'(o_hd), 1920);
        chk("R10", "short height max", int'(o_vd), 1440);
        launch(r, 1'b1, 1'b0, z);
        compare_all("wide", r, 1'b1);
        chk("R6", "wide width max", int'(o_hd), 2048);
        chk("R10", "tall height kept", int'(o_vd), 1500);
    endtask

    task automatic t_order();
        int r[8] = '{640, 640, 1000, 700, 400, 0, 0, 0};
        int s[8] = '{1027, 1043, 1605, 2003, 600, 601, 700, 800};
        int z[8] = '{default: 0};
        launch(r, 1'b0, 1'b0, z);
        compare_all("order", r, 1'b0);
        chk("R8", "h sync end after total step", int'(o_hse), 712);
        chk("R12", "v sync start raised past end", int'(o_vsb), 481);
        launch(s, 1'b0, 1'b0, z);
        compare_all("sync_len", s, 1'b0);
        chk("R8", "h sync length limited", int'(o_hse), 1288);
        chk("R12", "v sync length limited", int'(o_vse), 616);
        chk("R4", "unaligned h disp rounded", int'(o_hd), 1024);
    endtask

    task automatic t_ignore_busy_start();
        int r[8] = '{1024, 1048, 1184, 1344, 768, 771, 777, 806};
        int p[8] = '{default: 65535};
        launch(r, 1'b1, 1'b1, p);
        compare_all("R3", r, 1'b1);
        chk("R3", "second start left result", int'(o_hd), 1024);
    endtask

    task automatic t_hold();
        int kd = int'(o_hd), kt = int'(o_vt), kc = int'(changed);
        int p[8] = '{700, 700, 700, 700, 500, 500, 500, 500};
        drive_req(p, 1'b0);
        repeat (5) @(posedge clk);
        #1;
        chk("R14", "h disp held", int'(o_hd), kd);
        chk("R14", "v total held", int'(o_vt), kt);
        chk("R14", "changed held", int'(changed), kc);
        chk("R14", "still idle", int'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_legal();
        t_caps();
        t_gen_sel();
        t_order();
        t_ignore_busy_start();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule